// File: doc/BRIEF.md
# Time-Aware Gate Scheduler

This block controls the transmit gates at the egress of one Ethernet port. It holds a short list of schedule entries. Each entry gives a duration in time ticks and an eight-bit gate vector with one open or closed bit per priority queue. The scheduler steps through the entries in order, advancing on a free-running tick input. After the last entry it returns to the first, so the whole list repeats with a hyperperiod equal to the sum of the entry durations. The vector of the active entry is driven out as the current gate mask. The vectors may open several queues at once (overlapping windows) or a single queue (exclusive windows).

On each tick, while no frame is in flight, the block looks at the queues that report a frame ready. A queue is eligible when its gate is open and its head frame fits in the ticks left in the current entry. This acts as the guard band: no frame may start so late that it would run past the gate closing. Among the eligible queues, the highest-numbered queue wins. The winner is granted and keeps the grant until the transmitter reports completion, and it is never preempted. A one-cycle pulse marks each return to entry 0.

Top module: `tas_gate_sched`

## Requirements
- R1: After reset, `gate_mask` is 0, `grant` is 0 and `cycle_start` is 0, and every list entry holds duration 0 with all gates closed.
- R2: A write with `cfg_we` high stores `cfg_dur` and `cfg_mask` in entry `cfg_addr`. `gate_mask` always shows the gate vector of the active entry, where bit i is the gate of queue i and 1 means open.
- R3: After reset, entry 0 is active. An entry stays active for `max(duration,1)` ticks, then the next entry becomes active. After entry DEPTH-1 the list wraps to entry 0.
- R4: `cycle_start` is high for exactly one clock cycle, the cycle after the tick that wraps the list to entry 0.
- R5: A queue is granted only if its gate bit in `gate_mask` was set in the cycle of the deciding tick.
- R6: Guard band: a queue is eligible only if its head length satisfies `q_len <= max(duration,1) - elapsed`, where elapsed is the number of ticks already spent in the active entry when the deciding tick arrives.
- R7: Strict priority: among eligible ready queues, the highest index wins. This holds both when several gates are open and when only one gate is open.
- R8: A decision is taken only in a cycle with `tick` high, `grant` low and `tx_done` low. `grant` and `grant_q` change in the following cycle.
- R9: Once set, `grant` and `grant_q` hold until `tx_done`, and no higher-priority arrival preempts them. `grant` falls in the cycle after `tx_done`.
- R10: `q_len` packs the head length of queue i, in ticks, at bits [16i+15:16i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Schedule time tick, one cycle wide |
| cfg_we | input | 1 | List entry write strobe |
| cfg_addr | input | 3 | Entry index to write |
| cfg_dur | input | 16 | Entry duration in ticks |
| cfg_mask | input | 8 | Entry gate vector |
| q_ready | input | 8 | Frame-ready flag per queue |
| q_len | input | 128 | Head frame length per queue, in ticks |
| tx_done | input | 1 | Transmitter finished the granted frame |
| gate_mask | output | 8 | Gate vector of the active entry |
| grant | output | 1 | A queue is granted |
| grant_q | output | 3 | Index of the granted queue |
| cycle_start | output | 1 | Pulse on return to entry 0 |

## Verification
The bench builds the block with its defaults: eight queues, an eight-entry list, 16-bit durations and 16-bit lengths. It programs a 29-tick hyperperiod that mixes overlapping, exclusive, fully open and fully closed entries, plus one zero-duration entry. This brings within reach exact-fit and one-tick-over guard cases, the wrap and its pulse, and the one-tick entry. The hold and no-preemption behaviour is checked with a higher queue arriving during a grant.

// File: rtl/tas_gate_sched.sv
module tas_gate_sched #(
  parameter int NQ    = 8,
  parameter int DEPTH = 8,
  parameter int DUR_W = 16,
  parameter int LEN_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  cfg_we,
  input  logic [$clog2(DEPTH)-1:0] cfg_addr,
  input  logic [DUR_W-1:0]      cfg_dur,
  input  logic [NQ-1:0]         cfg_mask,
  input  logic [NQ-1:0]         q_ready,
  input  logic [NQ*LEN_W-1:0]   q_len,
  input  logic                  tx_done,
  output logic [NQ-1:0]         gate_mask,
  output logic                  grant,
  output logic [$clog2(NQ)-1:0] grant_q,
  output logic                  cycle_start
);
  localparam int AW = $clog2(DEPTH);
  localparam int QW = $clog2(NQ);

  logic [DUR_W-1:0] dur_mem  [DEPTH];
  logic [NQ-1:0]    mask_mem [DEPTH];
  logic [AW-1:0]    idx;
  logic [DUR_W-1:0] cnt;
  logic [DUR_W-1:0] dur_eff, remain;
  logic             last_tick;
  logic [NQ-1:0]    elig;
  logic             pick_ok;
  logic [QW-1:0]    pick_q;

  assign dur_eff   = (dur_mem[idx] == '0) ? DUR_W'(1) : dur_mem[idx];
  assign remain    = (cnt >= dur_eff) ? '0 : dur_eff - cnt;
  assign last_tick = ({1'b0, cnt} + 1'b1) >= {1'b0, dur_eff};
  assign gate_mask = mask_mem[idx];

  for (genvar q = 0; q < NQ; q++) begin : g_elig
    assign elig[q] = q_ready[q] && gate_mask[q] &&
                     (q_len[q*LEN_W +: LEN_W] <= LEN_W'(remain));
  end

  always_comb begin
    pick_ok = 1'b0;
    pick_q  = '0;
    for (int q = 0; q < NQ; q++) begin
      if (elig[q]) begin
        pick_ok = 1'b1;
        pick_q  = QW'(q);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) begin
        dur_mem[e]  <= '0;
        mask_mem[e] <= '0;
      end
    end else if (cfg_we) begin
      dur_mem[cfg_addr]  <= cfg_dur;
      mask_mem[cfg_addr] <= cfg_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx         <= '0;
      cnt         <= '0;
      cycle_start <= 1'b0;
    end else begin
      cycle_start <= 1'b0;
      if (tick) begin
        if (last_tick) begin
          cnt <= '0;
          if (idx == AW'(DEPTH-1)) begin
            idx         <= '0;
            cycle_start <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant   <= 1'b0;
      grant_q <= '0;
    end else if (grant) begin
      if (tx_done) grant <= 1'b0;
    end else if (tick && !tx_done && pick_ok) begin
      grant   <= 1'b1;
      grant_q <= pick_q;
    end
  end
endmodule

module tas_gate_sched_chk #(
  parameter int NQ = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  tick,
  input logic                  tx_done,
  input logic [NQ-1:0]         gate_mask,
  input logic                  grant,
  input logic [$clog2(NQ)-1:0] grant_q,
  input logic                  cycle_start
);
  logic [NQ-1:0] mask_d;
  always_ff @(posedge clk) mask_d <= gate_mask;

  // R5
  gate_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> mask_d[grant_q]);

  // R8
  tick_decide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant) |-> $past(tick) && !$past(tx_done));

  // R9
  hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && !tx_done) |=> (grant && $stable(grant_q)));

  // R9
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && tx_done) |=> !grant);

  // R4
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |=> !cycle_start);
endmodule

bind tas_gate_sched tas_gate_sched_chk #(.NQ(NQ)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .tx_done(tx_done),
  .gate_mask(gate_mask), .grant(grant), .grant_q(grant_q),
  .cycle_start(cycle_start)
);

// File: tb/tb_tas_gate_sched.sv
module tb_tas_gate_sched;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic         cfg_we = 1'b0;
  logic [2:0]   cfg_addr = '0;
  logic [15:0]  cfg_dur = '0;
  logic [7:0]   cfg_mask = '0;
  logic [7:0]   q_ready = '0;
  logic [127:0] q_len = '0;
  logic         tx_done = 1'b0;
  logic [7:0]   gate_mask;
  logic         grant;
  logic [2:0]   grant_q;
  logic         cycle_start;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #10 clk = ~clk;

  tas_gate_sched dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_dur(cfg_dur), .cfg_mask(cfg_mask),
    .q_ready(q_ready), .q_len(q_len), .tx_done(tx_done),
    .gate_mask(gate_mask), .grant(grant), .grant_q(grant_q),
    .cycle_start(cycle_start)
  );

  // schedule: 29-tick hyperperiod
  localparam logic [15:0] DURS  [8] = '{16'd10, 16'd5, 16'd4, 16'd0, 16'd3, 16'd2, 16'd2, 16'd2};
  localparam logic [7:0]  MASKS [8] = '{8'h81, 8'h0C, 8'hFF, 8'h10, 8'h00, 8'h02, 8'h04, 8'h08};

  // {adv, ready, len_hi(q4..7), len_lo(q0..3), exp_mask, exp_grant, exp_q}
  localparam int NV = 11;
  localparam logic [59:0] VEC [NV] = '{
    {8'd0,  8'h81, 16'd3,  16'd3,  8'h81, 1'b1, 3'd7},  // R7 overlap
    {8'd0,  8'h01, 16'd3,  16'd10, 8'h81, 1'b1, 3'd0},  // R6 exact fit
    {8'd0,  8'h01, 16'd3,  16'd11, 8'h81, 1'b0, 3'd0},  // R6 one over
    {8'd7,  8'h81, 16'd4,  16'd3,  8'h81, 1'b1, 3'd0},  // R6 high blocked
    {8'd10, 8'h81, 16'd1,  16'd1,  8'h0C, 1'b0, 3'd0},  // R5 closed
    {8'd12, 8'h0C, 16'd3,  16'd3,  8'h0C, 1'b1, 3'd3},  // R7
    {8'd15, 8'hFF, 16'd4,  16'd4,  8'hFF, 1'b1, 3'd7},  // R7 all open
    {8'd19, 8'hFF, 16'd1,  16'd1,  8'h10, 1'b1, 3'd4},  // R3 zero dur
    {8'd20, 8'hFF, 16'd1,  16'd1,  8'h00, 1'b0, 3'd0},  // R5 all closed
    {8'd29, 8'h80, 16'd10, 16'd10, 8'h81, 1'b1, 3'd7},  // R3 wrap
    {8'd28, 8'h08, 16'd9,  16'd1,  8'h08, 1'b1, 3'd3}   // R10 packing
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(posedge clk);
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic restart();
    @(negedge clk);
    rst_n = 1'b0; q_ready = '0; tx_done = 1'b0; tick = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int e = 0; e < 8; e++) begin
      cfg_we = 1'b1; cfg_addr = 3'(e); cfg_dur = DURS[e]; cfg_mask = MASKS[e];
      @(negedge clk);
    end
    cfg_we = 1'b0;
  endtask

  task automatic set_lens(input logic [15:0] hi, input logic [15:0] lo);
    for (int q = 0; q < 8; q++) q_len[q*16 +: 16] = (q >= 4) ? hi : lo;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 gate_mask", gate_mask, 0);
    chk("R1 grant", grant, 0);
    chk("R1 cycle_start", cycle_start, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 entries closed", gate_mask, 0);

    for (int v = 0; v < NV; v++) begin
      restart();
      tick_n(int'(VEC[v][59:52]));
      chk("R2 gate_mask", gate_mask, VEC[v][11:4]);
      q_ready = VEC[v][51:44];
      set_lens(VEC[v][43:28], VEC[v][27:12]);
      @(negedge clk);
      chk("R8 no pick without tick", grant, 0);
      tick_n(1);
      chk("R5/R6/R7 grant", grant, VEC[v][3]);
      if (VEC[v][3]) chk("R7/R10 grant_q", grant_q, VEC[v][2:0]);
    end

    // R4 cycle_start pulse on wrap
    restart();
    tick_n(28);
    chk("R4 no pulse before wrap", cycle_start, 0);
    tick_n(1);
    chk("R4 pulse on wrap", cycle_start, 1);
    chk("R3 entry 0 after wrap", gate_mask, 8'h81);
    @(negedge clk);
    chk("R4 pulse one cycle", cycle_start, 0);

    // R9 hold and no preemption
    restart();
    q_ready = 8'h01; set_lens(16'd2, 16'd2);
    tick_n(1);
    chk("R9 initial grant q0", grant_q, 0);
    q_ready = 8'h81; set_lens(16'd1, 16'd1);
    tick_n(2);
    chk("R9 grant held", grant, 1);
    chk("R9 no preemption", grant_q, 0);
    tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
    chk("R9 release after done", grant, 0);
    @(negedge clk);
    chk("R8 no pick between ticks", grant, 0);
    tick_n(1);
    chk("R8 re-pick at tick", grant_q, 7);
    chk("R8 re-pick grant", grant, 1);

    ended = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule